// File: doc/BRIEF.md
# Segmented Memory Protection Checker

This block watches a microcontroller memory bus and rules on every access, in the same cycle, against a four-segment protection map. Segment 0 is a fixed 512-byte information window. Segments 1, 2 and 3 divide a protected address span at two boundaries that software can move. Each segment has its own read, write and execute permission. Some address windows are never checked: the peripheral registers, the SRAM, the interrupt vectors, and any address outside both the information window and the protected span.

A small configuration port holds the two boundaries, the twelve permission bits and a fault-clear control. Firmware sets up the map on every change of context. A typical task setting makes the running task's code execute-only and its data read-write. A typical supervisor setting opens everything above the first boundary for data.

A denied access raises a sticky fault flag and stores the offending address and access kind. A second denial while the flag is set keeps the first record and sets an overflow bit. The access side is a plain valid strobe with a same-cycle verdict. The checker never applies back-pressure, because it has no ready signal and cannot stall the bus.

Top module: `mem_guard`

## Requirements
- R1: Access kind codes are 0 for fetch, 1 for read, 2 for write, and 3, which is treated as a read. A fetch needs the segment's X bit, a read needs R and a write needs W. A checked access whose needed bit is clear is denied.
- R2: Segment 0 is fixed at INFO_BASE (0x01800) and spans INFO_SIZE (512) bytes. Its permissions are bits [2:0] of the permission register and can be rewritten at any time. The address one past its end is not part of it.
- R3: The boundaries are written through selectors 0 (boundary 1) and 1 (boundary 2) as byte addresses. The low GRAN_LOG2 (4) bits are dropped, and a read returns the rounded address. Segment selection uses half-open ranges: an address equal to a boundary belongs to the higher segment. Segment 1 starts at SPAN_LO and segment 3 ends below SPAN_HI.
- R4: When boundary 1 lies above boundary 2, segment 2 is empty. Addresses at or above boundary 2 fall in segment 3, and addresses below it fall in segment 1.
- R5: The following accesses are always allowed, whatever the permissions: the peripheral window (0x00000–0x00FFF), the SRAM window (0x01C00–0x023FF), the vector window (0x0FF80–0x0FFFF), and any other address outside both the information window and the span.
- R6: acc_allow and acc_deny respond combinationally in the cycle acc_valid is high. Both are low when acc_valid is low.
- R7: A denial with no fault pending sets fault_flag and stores fault_addr and fault_kind on the next rising edge. They hold until a clear.
- R8: A denial while fault_flag is set leaves the stored record unchanged and sets fault_ovf.
- R9: Writing selector 3 with bit 0 set clears fault_flag and fault_ovf. A denial in the same cycle as the clear is stored as a new record, with fault_ovf low.
- R10: The permission register (selector 2) holds segment s in bits [3s+2:3s], ordered R at bit 3s, W at 3s+1 and X at 3s+2. Selector 3 reads {fault_kind, fault_ovf, fault_flag} in bits [3:0]. After reset both boundaries equal SPAN_LO, all permission bits are 1 and the fault state is clear.
- R11: With the task setting (0x0E0), a write just below boundary 1 is denied. With the supervisor setting (0x6E0), segment 3 accepts data writes but refuses fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register selector: 0 boundary 1, 1 boundary 2, 2 permissions, 3 fault control/status |
| cfg_wdata | input | DATA_W | Configuration write data |
| cfg_rdata | output | DATA_W | Combinational read-back of the selected register |
| acc_valid | input | 1 | Bus access present this cycle |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_kind | input | 2 | Access kind code (see R1) |
| acc_allow | output | 1 | Access permitted |
| acc_deny | output | 1 | Access refused |
| fault_flag | output | 1 | Sticky fault indication |
| fault_ovf | output | 1 | Another fault arrived while one was pending |
| fault_addr | output | ADDR_W | Address of the first stored fault |
| fault_kind | output | 2 | Kind of the first stored fault |

## Verification
The bench builds the block with its defaults: a 20-bit address, 16-byte boundary granularity and a 32-bit register port. With these values every window lies in a small map, so the bench can place accesses exactly on the window edges and on the boundaries, and a boundary write with low bits set shows the rounding. The small address space also lets it place boundary 1 above boundary 2 and probe the space where segment 2 would have been.

// File: rtl/mg_pkg.sv
package mg_pkg;
  localparam int NSEG   = 4;
  localparam int PERM_W = 3;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  // bit 0 = read, bit 1 = write, bit 2 = execute
  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

  function automatic logic perm_grants(perm_t p, logic [1:0] kind);
    case (kind)
      ACC_FETCH: perm_grants = p.x;
      ACC_WRITE: perm_grants = p.w;
      default:   perm_grants = p.r;
    endcase
  endfunction

  function automatic logic in_window(int unsigned a, int unsigned base, int unsigned size);
    in_window = (a >= base) && (a < base + size);
  endfunction
endpackage

// File: rtl/mg_cfg_regs.sv
module mg_cfg_regs
  import mg_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 32,
  parameter int GRAN_LOG2 = 4,
  parameter int unsigned SPAN_LO = 32'h04000,
  localparam int BND_W  = ADDR_W - GRAN_LOG2,
  localparam int PMAP_W = NSEG * PERM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [BND_W-1:0]  bnd_lo,
  output logic [BND_W-1:0]  bnd_hi,
  output logic [PMAP_W-1:0] perm_map,
  output logic              fault_clr
);
  localparam logic [ADDR_W-1:0] SPAN_LO_A = ADDR_W'(SPAN_LO);
  localparam logic [BND_W-1:0]  BND_RST   = SPAN_LO_A[ADDR_W-1:GRAN_LOG2];

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bnd_lo   <= BND_RST;
      bnd_hi   <= BND_RST;
      perm_map <= '1;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0:    bnd_lo   <= cfg_wdata[ADDR_W-1:GRAN_LOG2];
        2'd1:    bnd_hi   <= cfg_wdata[ADDR_W-1:GRAN_LOG2];
        2'd2:    perm_map <= cfg_wdata[PMAP_W-1:0];
        default: ;
      endcase
    end
  end

  assign fault_clr = cfg_we && (cfg_sel == 2'd3) && cfg_wdata[0];
endmodule

// File: rtl/mg_seg_decode.sv
module mg_seg_decode
  import mg_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int GRAN_LOG2 = 4,
  parameter int unsigned PER_BASE  = 32'h00000,
  parameter int unsigned PER_SIZE  = 32'h01000,
  parameter int unsigned INFO_BASE = 32'h01800,
  parameter int unsigned INFO_SIZE = 512,
  parameter int unsigned SRAM_BASE = 32'h01C00,
  parameter int unsigned SRAM_SIZE = 32'h00800,
  parameter int unsigned VEC_BASE  = 32'h0FF80,
  parameter int unsigned VEC_SIZE  = 32'h00080,
  parameter int unsigned SPAN_LO   = 32'h04000,
  parameter int unsigned SPAN_HI   = 32'h10000,
  localparam int BND_W  = ADDR_W - GRAN_LOG2,
  localparam int PMAP_W = NSEG * PERM_W
) (
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic [BND_W-1:0]  bnd_lo,
  input  logic [BND_W-1:0]  bnd_hi,
  input  logic [PMAP_W-1:0] perm_map,
  output logic              acc_allow,
  output logic              acc_deny
);
  perm_t seg_perm [NSEG];

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign seg_perm[s] = perm_map[s*PERM_W +: PERM_W];
  end

  int unsigned a32;
  logic        hit_info, hit_span, hit_free, checked, ok;
  logic [ADDR_W-1:0] b_lo, b_hi;
  logic [1:0]  seg;

  assign a32  = 32'(acc_addr);
  assign b_lo = {bnd_lo, {GRAN_LOG2{1'b0}}};
  assign b_hi = {bnd_hi, {GRAN_LOG2{1'b0}}};

  always_comb begin
    hit_info = in_window(a32, INFO_BASE, INFO_SIZE);
    hit_free = in_window(a32, PER_BASE, PER_SIZE) ||
               in_window(a32, SRAM_BASE, SRAM_SIZE) ||
               in_window(a32, VEC_BASE, VEC_SIZE);
    hit_span = (a32 >= SPAN_LO) && (a32 < SPAN_HI);
    checked  = !hit_free && (hit_info || hit_span);

    if (hit_info)              seg = 2'd0;
    else if (acc_addr >= b_hi) seg = 2'd3;
    else if (acc_addr >= b_lo) seg = 2'd2;
    else                       seg = 2'd1;

    ok = !checked || perm_grants(seg_perm[seg], acc_kind);
  end

  assign acc_allow = acc_valid && ok;
  assign acc_deny  = acc_valid && !ok;
endmodule

// File: rtl/mg_fault_log.sv
module mg_fault_log #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              deny,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        kind,
  output logic              flag,
  output logic              ovf,
  output logic [ADDR_W-1:0] rec_addr,
  output logic [1:0]        rec_kind
);
  logic take;
  assign take = deny && (clr || !flag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag     <= 1'b0;
      ovf      <= 1'b0;
      rec_addr <= '0;
      rec_kind <= '0;
    end else begin
      if (clr) begin
        flag <= deny;
        ovf  <= 1'b0;
      end else if (deny) begin
        flag <= 1'b1;
        if (flag) ovf <= 1'b1;
      end
      if (take) begin
        rec_addr <= addr;
        rec_kind <= kind;
      end
    end
  end
endmodule

// File: rtl/mem_guard.sv
module mem_guard
  import mg_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 32,
  parameter int GRAN_LOG2 = 4,
  parameter int unsigned PER_BASE  = 32'h00000,
  parameter int unsigned PER_SIZE  = 32'h01000,
  parameter int unsigned INFO_BASE = 32'h01800,
  parameter int unsigned INFO_SIZE = 512,
  parameter int unsigned SRAM_BASE = 32'h01C00,
  parameter int unsigned SRAM_SIZE = 32'h00800,
  parameter int unsigned VEC_BASE  = 32'h0FF80,
  parameter int unsigned VEC_SIZE  = 32'h00080,
  parameter int unsigned SPAN_LO   = 32'h04000,
  parameter int unsigned SPAN_HI   = 32'h10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  output logic              acc_allow,
  output logic              acc_deny,
  output logic              fault_flag,
  output logic              fault_ovf,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [1:0]        fault_kind
);
  localparam int BND_W  = ADDR_W - GRAN_LOG2;
  localparam int PMAP_W = NSEG * PERM_W;

  logic [BND_W-1:0]  bnd_lo, bnd_hi;
  logic [PMAP_W-1:0] perm_map;
  logic              fault_clr;

  mg_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GRAN_LOG2(GRAN_LOG2), .SPAN_LO(SPAN_LO)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bnd_lo(bnd_lo), .bnd_hi(bnd_hi),
    .perm_map(perm_map), .fault_clr(fault_clr)
  );

  mg_seg_decode #(
    .ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2),
    .PER_BASE(PER_BASE), .PER_SIZE(PER_SIZE),
    .INFO_BASE(INFO_BASE), .INFO_SIZE(INFO_SIZE),
    .SRAM_BASE(SRAM_BASE), .SRAM_SIZE(SRAM_SIZE),
    .VEC_BASE(VEC_BASE), .VEC_SIZE(VEC_SIZE),
    .SPAN_LO(SPAN_LO), .SPAN_HI(SPAN_HI)
  ) u_dec (
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_kind(acc_kind),
    .bnd_lo(bnd_lo), .bnd_hi(bnd_hi), .perm_map(perm_map),
    .acc_allow(acc_allow), .acc_deny(acc_deny)
  );

  mg_fault_log #(.ADDR_W(ADDR_W)) u_log (
    .clk(clk), .rst_n(rst_n), .clr(fault_clr), .deny(acc_deny),
    .addr(acc_addr), .kind(acc_kind),
    .flag(fault_flag), .ovf(fault_ovf),
    .rec_addr(fault_addr), .rec_kind(fault_kind)
  );

  always_comb begin
    case (cfg_sel)
      2'd0:    cfg_rdata = DATA_W'({bnd_lo, {GRAN_LOG2{1'b0}}});
      2'd1:    cfg_rdata = DATA_W'({bnd_hi, {GRAN_LOG2{1'b0}}});
      2'd2:    cfg_rdata = DATA_W'(perm_map);
      default: cfg_rdata = DATA_W'({fault_kind, fault_ovf, fault_flag});
    endcase
  end
endmodule

// File: rtl/mem_guard_chk.sv
module mem_guard_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32,
  parameter int unsigned PER_BASE = 32'h00000,
  parameter int unsigned PER_SIZE = 32'h01000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [1:0]        cfg_sel,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_allow,
  input logic              acc_deny,
  input logic              fault_flag,
  input logic              fault_ovf,
  input logic [ADDR_W-1:0] fault_addr,
  input logic [1:0]        fault_kind
);
  logic clr_req, in_per;
  assign clr_req = cfg_we && (cfg_sel == 2'd3) && cfg_wdata[0];
  assign in_per  = (32'(acc_addr) >= PER_BASE) && (32'(acc_addr) < PER_BASE + PER_SIZE);

  AST_PERIPH_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && in_per |-> acc_allow); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !acc_allow && !acc_deny); // R6
  AST_FAULT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_deny && !fault_flag |=> fault_flag && fault_addr == $past(acc_addr)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flag && !clr_req |=> fault_flag); // R7
  AST_RECORD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flag && !clr_req |=> $stable(fault_addr) && $stable(fault_kind)); // R8
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flag && acc_deny && !clr_req |=> fault_ovf); // R8
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && !acc_deny |=> !fault_flag && !fault_ovf); // R9
endmodule

bind mem_guard mem_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PER_BASE(PER_BASE), .PER_SIZE(PER_SIZE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_allow(acc_allow), .acc_deny(acc_deny), .fault_flag(fault_flag),
  .fault_ovf(fault_ovf), .fault_addr(fault_addr), .fault_kind(fault_kind)
);

// File: tb/mem_guard_test.sv
`timescale 1ns/1ps
module mem_guard_test;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_sel = 2'd0;
  logic [DATA_W-1:0] cfg_wdata = '0;
  logic [DATA_W-1:0] cfg_rdata;
  logic              acc_valid = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [1:0]        acc_kind = 2'd0;
  logic              acc_allow, acc_deny;
  logic              fault_flag, fault_ovf;
  logic [ADDR_W-1:0] fault_addr;
  logic [1:0]        fault_kind;

  int total = 0;
  int bad   = 0;
  bit exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  mem_guard uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_allow(acc_allow),
    .acc_deny(acc_deny), .fault_flag(fault_flag), .fault_ovf(fault_ovf),
    .fault_addr(fault_addr), .fault_kind(fault_kind)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard for each valid access, before the edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (acc_valid) begin
        if (exp_q.size() == 0) begin
          chk(32'd1, 32'd0, "scoreboard underrun");
        end else begin
          automatic bit    e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk({30'd0, acc_allow, acc_deny}, {30'd0, e, !e}, t);
        end
      end
    end
  end

  task automatic access(input logic [ADDR_W-1:0] a, input logic [1:0] k,
                        input bit allow_exp, input string tag);
    @(negedge clk);
    cfg_we = 1'b0;
    acc_valid = 1'b1; acc_addr = a; acc_kind = k;
    exp_q.push_back(allow_exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0;
    #1;
  endtask

  task automatic cfg_wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b0;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
  endtask

  task automatic cfg_rd(input logic [1:0] sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    acc_valid = 1'b0;
    cfg_sel = sel;
    #1;
    chk(cfg_rdata, exp, tag);
  endtask

  initial begin
    #(20 * 20000);
    chk(32'd1, 32'd0, "watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    cfg_rd(2'd0, 32'h04000, "R10 reset bnd1");
    cfg_rd(2'd1, 32'h04000, "R10 reset bnd2");
    cfg_rd(2'd2, 32'h00FFF, "R10 reset perms");
    cfg_rd(2'd3, 32'h0, "R10 reset fault status");
    access(20'h05000, 2'd1, 1'b1, "R10 reset perms allow");
    idle();
    chk({31'd0, fault_flag}, 32'd0, "R10 no fault after allowed");

    // task setting: b1=0x8000, b2=0xC000
    cfg_wr(2'd0, 32'h08000);
    cfg_wr(2'd1, 32'h0C000);
    cfg_wr(2'd2, 32'h000E0);
    access(20'h05000, 2'd0, 1'b1, "R1 fetch seg1 X");
    access(20'h05000, 2'd1, 1'b0, "R1 read seg1 denied");
    access(20'h08000, 2'd2, 1'b1, "R3 write at bnd1 is seg2");
    idle();
    chk({31'd0, fault_flag}, 32'd1, "R7 flag set");
    chk(32'(fault_addr), 32'h05000, "R7 fault addr");
    chk({30'd0, fault_kind}, 32'd1, "R7 fault kind");
    chk({31'd0, fault_ovf}, 32'd0, "R7 no overflow yet");

    access(20'h07FF0, 2'd2, 1'b0, "R11 stack write below bnd1");
    access(20'h08010, 2'd0, 1'b0, "R1 fetch seg2 denied");
    access(20'h0C000, 2'd1, 1'b0, "R3 read at bnd2 is seg3");
    access(20'h0BFFF, 2'd1, 1'b1, "R3 read below bnd2 seg2");
    access(20'h0BFFF, 2'd3, 1'b1, "R1 reserved kind acts as read");
    access(20'h00100, 2'd2, 1'b1, "R5 peripheral pass");
    access(20'h01C10, 2'd1, 1'b1, "R5 sram pass");
    access(20'h0FF90, 2'd2, 1'b1, "R5 vector pass");
    access(20'h02800, 2'd1, 1'b1, "R5 unmapped pass");
    access(20'h01800, 2'd1, 1'b0, "R2 info base denied");
    access(20'h019FF, 2'd1, 1'b0, "R2 info top denied");
    access(20'h01A00, 2'd1, 1'b1, "R2 past info window");
    idle();
    chk(32'(fault_addr), 32'h05000, "R8 first record kept");
    chk({31'd0, fault_ovf}, 32'd1, "R8 overflow set");
    cfg_rd(2'd3, 32'h7, "R10 status readback");

    cfg_wr(2'd3, 32'h1);
    chk({30'd0, fault_flag, fault_ovf}, 32'd0, "R9 clear");

    // R2 segment 0 rewritable
    cfg_wr(2'd2, 32'h000E1);
    access(20'h01800, 2'd1, 1'b1, "R2 info read now allowed");
    access(20'h01800, 2'd2, 1'b0, "R2 info write denied");
    idle();
    chk(32'(fault_addr), 32'h01800, "R7 new record addr");
    chk({30'd0, fault_kind}, 32'd2, "R7 new record kind");

    cfg_wr(2'd0, 32'h0900F);
    cfg_rd(2'd0, 32'h09000, "R3 granularity rounding");

    // R4 inverted boundaries
    cfg_wr(2'd0, 32'h0D000);
    cfg_wr(2'd1, 32'h0A000);
    access(20'h0B000, 2'd1, 1'b0, "R4 between bounds is seg3");
    access(20'h09000, 2'd1, 1'b0, "R4 below bnd2 is seg1 read");
    access(20'h09000, 2'd0, 1'b1, "R4 below bnd2 is seg1 fetch");
    access(20'h0CFF0, 2'd2, 1'b0, "R4 seg2 empty write");

    // R11 supervisor setting
    cfg_wr(2'd2, 32'h006E0);
    cfg_wr(2'd0, 32'h08000);
    cfg_wr(2'd1, 32'h0C000);
    access(20'h0C000, 2'd2, 1'b1, "R11 sup seg3 write");
    access(20'h0C000, 2'd0, 1'b0, "R11 sup seg3 fetch");
    access(20'h04000, 2'd0, 1'b1, "R11 sup span low fetch");
    access(20'h08000, 2'd1, 1'b1, "R11 sup seg2 read");
    access(20'h07FF0, 2'd2, 1'b0, "R11 sup seg1 write");
    idle();
    chk({31'd0, fault_flag}, 32'd1, "R9 flag pending before clear");

    // R9 clear with simultaneous fault
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 32'h1;
    acc_valid = 1'b1; acc_addr = 20'h06000; acc_kind = 2'd1;
    exp_q.push_back(1'b0);
    tag_q.push_back("R9 deny during clear");
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
    #1;
    chk({31'd0, fault_flag}, 32'd1, "R9 fresh flag");
    chk({31'd0, fault_ovf}, 32'd0, "R9 fresh ovf low");
    chk(32'(fault_addr), 32'h06000, "R9 fresh addr");

    // R6 idle outputs
    chk({30'd0, acc_allow, acc_deny}, 32'd0, "R6 idle outputs low");

    repeat (2) @(negedge clk);
    chk(32'(exp_q.size()), 32'd0, "scoreboard drained");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule